// File: doc/BRIEF.md
# Serial Flash Identification Reader

This block is a host-side SPI master. It fetches the identification bytes of an attached serial flash device. A one-cycle `start` pulse makes it lower chip select and shift out the identification command 9FH, most significant bit first. It then clocks in response bytes. Each leading byte equal to 7FH is a continuation marker: the block counts it and keeps reading. The first byte that differs from 7FH is taken as the manufacturer code. The two bytes after it are stored as the device identifier.

Once the second device byte has arrived, chip select is released and `done` pulses for one cycle. If the continuation limit is reached before any other byte shows up, the read is cut short at that byte and the error flag is raised. The serial clock runs in SPI mode 0: it idles low, MISO is sampled on the rising edge, and MOSI changes on the falling edge. Each SCK half period lasts a parameterised number of system clocks.

Top module: `jedec_id_reader`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sck` is low, and `done` and `err` are low.
- R2: Once `start` is accepted, the first 8 SCK cycles carry the command byte 9FH on `spi_mosi`, MSB first. `spi_mosi` holds steady while SCK is high.
- R3: SCK idles low and stays low whenever `spi_cs_n` is high. Each SCK half period lasts `HALF_DIV` clocks. From the clock edge that accepts `start` to the edge that raises `done`, exactly 16·`HALF_DIV`·(number of bytes transferred) clocks elapse.
- R4: Every received byte equal to 7FH ahead of the manufacturer code is counted in `cont_count` and skipped.
- R5: The first received byte that is not 7FH is reported on `mfr_code`.
- R6: The two bytes that follow the manufacturer code appear on `dev_id0` and `dev_id1`, in that order. Chip select is then released, so a good read spans n+4 bytes, where n is the number of continuation bytes.
- R7: When `MAX_CONT` consecutive 7FH bytes arrive, the read ends after that byte. In that case `err` is 1, `cont_count` equals `MAX_CONT`, the manufacturer and device outputs read 0, and the transfer spans 1+`MAX_CONT` bytes.
- R8: `done` is a single-cycle pulse, issued once per read, with chip select already high.
- R9: A `start` pulse that arrives while a read is in progress is ignored.
- R10: Results and `err` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an identification read (one-cycle pulse) |
| done | output | 1 | One-cycle pulse at the end of a read |
| err | output | 1 | Continuation limit reached |
| mfr_code | output | 8 | Manufacturer code byte |
| cont_count | output | $clog2(MAX_CONT+1) | Number of 7FH bytes seen |
| dev_id0 | output | 8 | First device identifier byte |
| dev_id1 | output | 8 | Second device identifier byte |
| spi_sck | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the block with `HALF_DIV` = 2 and the default `MAX_CONT` = 4. This keeps each transfer to a few hundred clocks, so it can sweep every continuation count from zero up to the abort case. Each count is run against manufacturer codes at the edges of the byte range, including 7EH and FFH, which sit next to the marker value. A serial model of the flash in the bench replays the prepared response bytes. It also counts SCK edges, so the exact byte count and duration of every read are checked, both for good reads and for the aborted one.

// File: rtl/jedec_id_reader.sv
module jedec_id_reader #(
  parameter int HALF_DIV = 4,
  parameter int MAX_CONT = 4,
  localparam int CW = $clog2(MAX_CONT + 1),
  localparam int DW = $clog2(HALF_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          err,
  output logic [7:0]    mfr_code,
  output logic [CW-1:0] cont_count,
  output logic [7:0]    dev_id0,
  output logic [7:0]    dev_id1,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam logic [7:0] ID_CMD = 8'h9F;
  localparam logic [7:0] CONT_MARK = 8'h7F;

  typedef enum logic [1:0] {PH_CMD, PH_MFR, PH_DEV0, PH_DEV1} phase_t;

  phase_t        phase;
  logic          busy;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sr, rx_sr;

  wire tick     = busy && (div_cnt == DW'(HALF_DIV - 1));
  wire byte_end = tick && spi_sck && (bit_cnt == 3'd7);

  assign spi_cs_n = ~busy;
  assign spi_mosi = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; spi_sck <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; tx_sr <= '0; rx_sr <= '0;
      phase <= PH_CMD; cont_count <= '0;
      mfr_code <= '0; dev_id0 <= '0; dev_id1 <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; div_cnt <= '0; bit_cnt <= '0;
          tx_sr <= ID_CMD; phase <= PH_CMD; err <= 1'b0;
          cont_count <= '0; mfr_code <= '0; dev_id0 <= '0; dev_id1 <= '0;
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          spi_sck <= ~spi_sck;
          if (!spi_sck) rx_sr <= {rx_sr[6:0], spi_miso};
          else begin
            tx_sr   <= {tx_sr[6:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (byte_end) begin
          unique case (phase)
            PH_CMD: phase <= PH_MFR;
            PH_MFR:
              if (rx_sr == CONT_MARK) begin
                cont_count <= cont_count + 1'b1;
                if (cont_count == CW'(MAX_CONT - 1)) begin
                  err <= 1'b1; busy <= 1'b0; done <= 1'b1;
                end
              end else begin
                mfr_code <= rx_sr;
                phase    <= PH_DEV0;
              end
            PH_DEV0: begin dev_id0 <= rx_sr; phase <= PH_DEV1; end
            PH_DEV1: begin dev_id1 <= rx_sr; busy <= 1'b0; done <= 1'b1; end
          endcase
        end
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3
  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R8
  AST_CONT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cont_count <= CW'(MAX_CONT)); // R7
  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (cont_count == CW'(MAX_CONT)) && spi_cs_n); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && !$past(start)) |-> $stable(mfr_code) && $stable(err)); // R10
endmodule

// File: tb/jedec_id_reader_bench.sv
module jedec_id_reader_bench;
  localparam int HALF = 2;
  localparam int MAXC = 4;
  localparam int CW = $clog2(MAXC + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, err, sck, cs_n, mosi, miso_q = 1'b0;
  wire  miso;
  logic [7:0] mfr, d0, d1;
  logic [CW-1:0] cont;
  assign miso = cs_n ? 1'bz : miso_q;

  always #4 clk = ~clk;

  jedec_id_reader #(.HALF_DIV(HALF), .MAX_CONT(MAXC)) u_jedec_id_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .mfr_code(mfr), .cont_count(cont), .dev_id0(d0), .dev_id1(d1),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  int total = 0, bad = 0;
  logic [7:0] resp [0:7];
  int rise_total = 0, fall_total = 0, rise_base = 0, fall_base = 0, done_total = 0;
  logic [7:0] cmd_sr = '0, cmd_cap = '0;

  always @(negedge cs_n) begin rise_base = rise_total; fall_base = fall_total; end
  always @(posedge sck) begin
    rise_total = rise_total + 1;
    if (rise_total - rise_base == 8) cmd_cap = {cmd_sr[6:0], mosi};
    cmd_sr = {cmd_sr[6:0], mosi};
  end
  always @(negedge sck) begin
    fall_total = fall_total + 1;
    if (fall_total - fall_base >= 8) begin
      int idx;
      idx = fall_total - fall_base - 8;
      if (idx < 64) miso_q = resp[idx/8][7 - (idx % 8)];
    end
  end
  always @(posedge clk) if (done) done_total <= done_total + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input logic [7:0] m, input logic [7:0] x0,
                     input logic [7:0] x1, input bit poke);
    int r0, dn0, cyc, nbytes;
    bit abort;
    for (int i = 0; i < 8; i++) resp[i] = 8'h00;
    for (int i = 0; i < n; i++) resp[i] = 8'h7F;
    if (n < MAXC) begin resp[n] = m; resp[n+1] = x0; resp[n+2] = x1; end
    abort  = (n >= MAXC);
    nbytes = abort ? 1 + MAXC : n + 4;
    r0 = rise_total; dn0 = done_total;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (poke && cyc == 20) start = 1'b1; else start = 1'b0;
      @(negedge clk) cyc++;
    end
    start = 1'b0;
    chk(cyc < 5000, "R8 watchdog", cyc, 0);
    chk(cyc == 1 + 16 * HALF * nbytes, "R3 duration", cyc, 1 + 16 * HALF * nbytes);
    chk(rise_total - r0 == 8 * nbytes, "R6 byte count", rise_total - r0, 8 * nbytes);
    chk(cmd_cap == 8'h9F, "R2 opcode", cmd_cap, 8'h9F);
    chk(cs_n == 1'b1, "R8 cs released", cs_n, 1);
    if (abort) begin
      chk(err == 1'b1, "R7 err", err, 1);
      chk(cont == CW'(MAXC), "R7 cont", cont, MAXC);
      chk(mfr == 8'h00 && d0 == 8'h00 && d1 == 8'h00, "R7 outputs zero", mfr, 0);
    end else begin
      chk(err == 1'b0, "R7 no err", err, 0);
      chk(cont == CW'(n), "R4 cont", cont, n);
      chk(mfr == m, "R5 mfr", mfr, m);
      chk(d0 == x0, "R6 dev0", d0, x0);
      chk(d1 == x1, "R6 dev1", d1, x1);
    end
    repeat (12) @(negedge clk);
    chk(done_total - dn0 == 1, poke ? "R9 single read" : "R8 one done", done_total - dn0, 1);
    chk(cs_n && !sck, "R9 idle after", {cs_n, sck}, 2);
    chk(abort ? (err == 1'b1) : (mfr == m && d1 == x1), "R10 hold", mfr, m);
  endtask

  initial begin
    logic [7:0] codes [0:3];
    codes[0] = 8'h1F; codes[1] = 8'h00; codes[2] = 8'hFF; codes[3] = 8'h7E;
    for (int i = 0; i < 8; i++) resp[i] = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins", {cs_n, sck}, 2);
    chk(done == 1'b0 && err == 1'b0, "R1 flags", {done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 0; n <= MAXC; n++)
      for (int k = 0; k < 4; k++)
        run(n, codes[k], codes[k] ^ 8'(n * 16 + 3), ~codes[k] + 8'(n), 1'b0);
    run(1, 8'h1F, 8'h25, 8'h00, 1'b1);
    run(MAXC, 8'h1F, 8'h00, 8'h00, 1'b1);
    run(2, 8'h80, 8'h7F, 8'h7F, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule